// File: doc/BRIEF.md
# Bus Strobe and Base Decoder

This block is the glue logic between a 6502-style expansion bus and a peripheral that expects Intel-style separate read and write strobes. The host side provides one read/write line, the PHI2 clock phase, an active-low I/O area select and the low eight address bits. The block turns these into active-low read and write strobes, an active-low chip select and a 2-bit register offset for a peripheral that uses four consecutive addresses.

Two decode modes are available. In comparator mode, a 4-bit bank number is compared against address bits 7:4. The bank number is captured while reset is held and then stays fixed. The result places the peripheral in any of the sixteen 16-byte slots of the I/O page, and its four registers mirror across that slot. In fixed mode, a 3-input one-of-eight decoder produces the strobes directly. The chip select is then held active, and the device answers only in the lowest 32 bytes of the page.

The peripheral's active-low interrupt goes out on a shared wired-OR line. The block only pulls that line low and otherwise releases it.

Top module: `bus_strobe_decoder`

## Requirements
- R1: `rd_n` is low only while `bus_rw` is 1, `bus_phi2` is 1 and `io_sel_n` is 0.
- R2: `wr_n` is low only while `bus_rw` is 0, `bus_phi2` is 1 and `io_sel_n` is 0.
- R3: While `bus_phi2` is 0 or `io_sel_n` is 1, both `rd_n` and `wr_n` are 1, in either mode.
- R4: Comparator mode is selected by `mode_fixed` = 0. In this mode, `cs_n` is 0 exactly when `io_sel_n` is 0 and `bus_addr[7:4]` equals the captured bank. The strobes fire only when `cs_n` is 0. The four registers repeat every 4 bytes across the 16-byte slot.
- R5: In comparator mode, `reg_ofs` equals `bus_addr[1:0]` when the slot matches and is 0 otherwise. In fixed mode, `reg_ofs` always equals `bus_addr[1:0]`.
- R6: Fixed mode is selected by `mode_fixed` = 1. In this mode, the decoder select is {`bus_addr[6]`, `bus_addr[5]`, `bus_rw`}, with `bus_rw` as the least significant bit. Decoder output 0 drives `wr_n` and output 1 drives `rd_n`. The decoder is enabled only when `bus_phi2` is 1, `io_sel_n` is 0 and `bus_addr[7]` is 0. The device therefore answers only at page offsets 0x00 to 0x1F.
- R7: In fixed mode, `cs_n` is held at 0 at all times.
- R8: `bank_cfg` is captured on every clock edge while `rst_n` is 0. Changes to `bank_cfg` after reset is released have no effect on decoding.
- R9: When `per_irq_n` is 0, `irq_line` is driven to 0. When `per_irq_n` is 1, `irq_line` is released to high impedance, so another agent or the pull-up decides its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to capture the bank number |
| rst_n | input | 1 | Active-low reset; the bank is captured while it is low |
| mode_fixed | input | 1 | 0 selects comparator mode, 1 selects fixed mode |
| bank_cfg | input | 4 | Slot number for comparator mode |
| bus_rw | input | 1 | Host read/write line (1 = read) |
| bus_phi2 | input | 1 | Host clock phase; strobes only in its high half |
| io_sel_n | input | 1 | Active-low I/O area select |
| bus_addr | input | 8 | Low address byte within the I/O page |
| rd_n | output | 1 | Active-low peripheral read strobe |
| wr_n | output | 1 | Active-low peripheral write strobe |
| cs_n | output | 1 | Active-low peripheral chip select |
| reg_ofs | output | 2 | Register offset presented to the peripheral |
| per_irq_n | input | 1 | Peripheral interrupt, active low |
| irq_line | inout | 1 | Shared open-drain interrupt line |

## Verification
The hardest condition to reach is a bank change after reset. A wrong design can look correct here, because the new slot simply starts answering. To catch that, the bench first captures one bank under reset, then drives a different value on `bank_cfg`, and probes both the old slot and the new one. It then applies a second reset to show that the new value is taken only through reset. The wired-OR case is the other hard one. It needs a second pull-down agent and a pull-up on the line, so that the bench can tell the released state apart from an actively driven one.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  typedef enum logic {
    DEC_CMP   = 1'b0,
    DEC_FIXED = 1'b1
  } dec_mode_e;

  // Slot comparison: the upper address nibble against the captured bank.
  function automatic logic slot_match(input logic [3:0] addr_hi,
                                      input logic [3:0] bank);
    return addr_hi == bank;
  endfunction

  // Fixed-decoder select word, with bus R/W as the least significant bit.
  function automatic logic [2:0] fixed_sel(input logic a6,
                                           input logic a5,
                                           input logic rw);
    return {a6, a5, rw};
  endfunction

endpackage

// File: rtl/bsd_bank_reg.sv
module bsd_bank_reg #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BANK_W-1:0] bank_cfg,
  output logic [BANK_W-1:0] bank_q
);
  // Follows the configuration input while reset is held, then freezes.
  always_ff @(posedge clk) begin
    if (!rst_n) bank_q <= bank_cfg;
  end
endmodule

// File: rtl/bsd_slot_decode.sv
module bsd_slot_decode
  import bsd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 4,
  parameter int OFS_W  = 2
) (
  input  logic              bus_rw,
  input  logic              bus_phi2,
  input  logic              io_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BANK_W-1:0] bank_q,
  output logic              hit,
  output logic              rd_n,
  output logic              wr_n,
  output logic [OFS_W-1:0]  ofs
);
  localparam int SLOT_LSB = ADDR_W - BANK_W;

  logic strobe_win;

  always_comb begin
    hit        = !io_sel_n && slot_match(bus_addr[ADDR_W-1:SLOT_LSB], bank_q);
    strobe_win = hit && bus_phi2;
    rd_n       = !(strobe_win && bus_rw);
    wr_n       = !(strobe_win && !bus_rw);
    ofs        = hit ? bus_addr[OFS_W-1:0] : '0;
  end
endmodule

// File: rtl/bsd_fixed_decode.sv
module bsd_fixed_decode
  import bsd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              bus_rw,
  input  logic              bus_phi2,
  input  logic              io_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              dec_en,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int NOUT = 1 << SEL_W;

  logic [SEL_W-1:0] sel;
  logic [NOUT-1:0]  y_n;

  assign dec_en = bus_phi2 && !io_sel_n && !bus_addr[ADDR_W-1];
  assign sel    = fixed_sel(bus_addr[ADDR_W-2], bus_addr[ADDR_W-3], bus_rw);

  for (genvar k = 0; k < NOUT; k++) begin : g_out
    assign y_n[k] = !(dec_en && (sel == SEL_W'(k)));
  end

  assign wr_n = y_n[0];
  assign rd_n = y_n[1];
endmodule

// File: rtl/bsd_irq_od.sv
module bsd_irq_od (
  input  logic per_irq_n,
  output logic pull_low,
  inout  wire  irq_line
);
  assign pull_low = !per_irq_n;
  assign irq_line = pull_low ? 1'b0 : 1'bz;
endmodule

// File: rtl/bus_strobe_decoder.sv
module bus_strobe_decoder
  import bsd_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 4,
  parameter int OFS_W  = 2,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_fixed,
  input  logic [BANK_W-1:0] bank_cfg,
  input  logic              bus_rw,
  input  logic              bus_phi2,
  input  logic              io_sel_n,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rd_n,
  output logic              wr_n,
  output logic              cs_n,
  output logic [OFS_W-1:0]  reg_ofs,
  input  logic              per_irq_n,
  inout  wire               irq_line
);
  dec_mode_e         mode;
  logic [BANK_W-1:0] bank_q;
  logic              cmp_hit, cmp_rd_n, cmp_wr_n;
  logic [OFS_W-1:0]  cmp_ofs;
  logic              fix_en, fix_rd_n, fix_wr_n;
  logic              irq_pull;

  assign mode = dec_mode_e'(mode_fixed);

  bsd_bank_reg #(.BANK_W(BANK_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .bank_cfg(bank_cfg), .bank_q(bank_q)
  );

  bsd_slot_decode #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .OFS_W(OFS_W)) u_slot (
    .bus_rw(bus_rw), .bus_phi2(bus_phi2), .io_sel_n(io_sel_n),
    .bus_addr(bus_addr), .bank_q(bank_q), .hit(cmp_hit),
    .rd_n(cmp_rd_n), .wr_n(cmp_wr_n), .ofs(cmp_ofs)
  );

  bsd_fixed_decode #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_fixed (
    .bus_rw(bus_rw), .bus_phi2(bus_phi2), .io_sel_n(io_sel_n),
    .bus_addr(bus_addr), .dec_en(fix_en), .rd_n(fix_rd_n), .wr_n(fix_wr_n)
  );

  bsd_irq_od u_irq (
    .per_irq_n(per_irq_n), .pull_low(irq_pull), .irq_line(irq_line)
  );

  always_comb begin
    if (mode == DEC_FIXED) begin
      rd_n    = fix_rd_n;
      wr_n    = fix_wr_n;
      cs_n    = 1'b0;
      reg_ofs = bus_addr[OFS_W-1:0];
    end else begin
      rd_n    = cmp_rd_n;
      wr_n    = cmp_wr_n;
      cs_n    = !cmp_hit;
      reg_ofs = cmp_ofs;
    end
  end
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker #(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_fixed,
  input logic              bus_rw,
  input logic              bus_phi2,
  input logic              io_sel_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              rd_n,
  input logic              wr_n,
  input logic              cs_n,
  input logic [BANK_W-1:0] bank_q
);
  AST_RD_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (bus_rw && bus_phi2 && !io_sel_n)); // R1
  AST_WR_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!bus_rw && bus_phi2 && !io_sel_n)); // R2
  AST_IDLE_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_phi2 || io_sel_n) |-> (rd_n && wr_n)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n}) <= 1); // R3
  AST_SLOT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_fixed && !cs_n) |-> (bus_addr[ADDR_W-1:ADDR_W-BANK_W] == bank_q)); // R4
  AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_fixed && (!rd_n || !wr_n)) |-> !cs_n); // R4
  AST_FIXED_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_fixed && (bus_addr[ADDR_W-1] || bus_addr[ADDR_W-2] || bus_addr[ADDR_W-3]))
      |-> (rd_n && wr_n)); // R6
  AST_FIXED_CS: assert property (@(posedge clk) disable iff (!rst_n)
    mode_fixed |-> !cs_n); // R7
  AST_BANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(bank_q)); // R8
endmodule

bind bus_strobe_decoder bsd_checker #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_fixed(mode_fixed), .bus_rw(bus_rw),
  .bus_phi2(bus_phi2), .io_sel_n(io_sel_n), .bus_addr(bus_addr),
  .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n), .bank_q(bank_q)
);

// File: tb/bus_strobe_decoder_bench.sv
module bus_strobe_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_fixed = 1'b0;
  logic [3:0] bank_cfg = 4'hD;
  logic       bus_rw = 1'b1, bus_phi2 = 1'b0, io_sel_n = 1'b1;
  logic [7:0] bus_addr = 8'h00;
  logic       rd_n, wr_n, cs_n;
  logic [1:0] reg_ofs;
  logic       per_irq_n = 1'b1;
  logic       other_pull = 1'b0;
  wire        irq_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pullup (irq_line);
  assign irq_line = other_pull ? 1'b0 : 1'bz;

  bus_strobe_decoder u_bus_strobe_decoder (
    .clk(clk), .rst_n(rst_n), .mode_fixed(mode_fixed), .bank_cfg(bank_cfg),
    .bus_rw(bus_rw), .bus_phi2(bus_phi2), .io_sel_n(io_sel_n),
    .bus_addr(bus_addr), .rd_n(rd_n), .wr_n(wr_n), .cs_n(cs_n),
    .reg_ofs(reg_ofs), .per_irq_n(per_irq_n), .irq_line(irq_line)
  );

  // {mode, rw, phi2, io_sel_n, addr[7:0], exp rd_n, exp wr_n, exp cs_n, exp ofs[1:0]}
  // Captured bank is 4'hD throughout the table.
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hD2, 1'b0, 1'b1, 1'b0, 2'd2}, // R1 R4 R5 read in slot
    {1'b0, 1'b0, 1'b1, 1'b0, 8'hDD, 1'b1, 1'b0, 1'b0, 2'd1}, // R2 R4 write, mirror
    {1'b0, 1'b1, 1'b0, 1'b0, 8'hD3, 1'b1, 1'b1, 1'b0, 2'd3}, // R3 phi2 low
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b1, 2'd0}, // R4 R5 wrong slot
    {1'b0, 1'b0, 1'b1, 1'b1, 8'hD0, 1'b1, 1'b1, 1'b1, 2'd0}, // R3 io select high
    {1'b0, 1'b1, 1'b1, 1'b0, 8'hDF, 1'b0, 1'b1, 1'b0, 2'd3}, // R4 top of slot
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h05, 1'b1, 1'b0, 1'b0, 2'd1}, // R6 fixed write
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h1E, 1'b0, 1'b1, 1'b0, 2'd2}, // R6 fixed read
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h20, 1'b1, 1'b1, 1'b0, 2'd0}, // R6 A5 set
    {1'b1, 1'b0, 1'b1, 1'b0, 8'h80, 1'b1, 1'b1, 1'b0, 2'd0}, // R6 A7 set
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h01, 1'b1, 1'b1, 1'b0, 2'd1}, // R3 R7 phi2 low
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 1'b1, 1'b0, 2'd0}  // R3 R7 io high
  };

  function automatic string vec_req(input int i);
    case (i)
      0, 1, 5: return "R4";
      2, 4:    return "R3";
      3:       return "R5";
      10, 11:  return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic check_bit(input string req, input string what,
                           input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic check_outs(input string req, input logic er, input logic ew,
                            input logic ec, input logic [1:0] eo);
    checks++;
    if ({rd_n, wr_n, cs_n, reg_ofs} !== {er, ew, ec, eo}) begin
      failures++;
      $display("FAIL %s rd/wr/cs/ofs actual=%b%b%b%0d expected=%b%b%b%0d",
               req, rd_n, wr_n, cs_n, reg_ofs, er, ew, ec, eo);
    end
  endtask

  task automatic apply(input logic m, input logic rw, input logic p,
                       input logic s, input logic [7:0] a);
    @(negedge clk);
    mode_fixed = m; bus_rw = rw; bus_phi2 = p; io_sel_n = s; bus_addr = a;
    #2;
  endtask

  task automatic do_reset(input logic [3:0] b);
    @(negedge clk);
    rst_n = 1'b0; bank_cfg = b; bus_phi2 = 1'b0; io_sel_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    // Reset state: idle bus gives both strobes high (R3).
    repeat (3) @(negedge clk);
    #2;
    check_outs("R3", 1'b1, 1'b1, 1'b1, 2'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][16], VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12:5]);
      check_outs(vec_req(i), VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1:0]);
    end

    // R8: bank change after reset is ignored.
    @(negedge clk);
    bank_cfg = 4'h3;
    repeat (2) @(negedge clk);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h31);
    check_outs("R8", 1'b1, 1'b1, 1'b1, 2'd0);
    apply(1'b0, 1'b1, 1'b1, 1'b0, 8'hD1);
    check_outs("R8", 1'b0, 1'b1, 1'b0, 2'd1);
    // R8: a new reset captures the new bank.
    do_reset(4'h3);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h36);
    check_outs("R8", 1'b1, 1'b0, 1'b0, 2'd2);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'hD6);
    check_outs("R8", 1'b1, 1'b1, 1'b1, 2'd0);
    // R1 R2: no strobe outside its direction.
    apply(1'b0, 1'b1, 1'b1, 1'b0, 8'h30);
    check_bit("R2", "wr_n on read", wr_n, 1'b1);
    apply(1'b0, 1'b0, 1'b1, 1'b0, 8'h30);
    check_bit("R1", "rd_n on write", rd_n, 1'b1);

    // R9: open-drain interrupt.
    apply(1'b0, 1'b1, 1'b0, 1'b1, 8'h00);
    check_bit("R9", "irq released", irq_line, 1'b1);
    per_irq_n = 1'b0; #1;
    check_bit("R9", "irq pulled", irq_line, 1'b0);
    per_irq_n = 1'b1; other_pull = 1'b1; #1;
    check_bit("R9", "irq other agent", irq_line, 1'b0);
    other_pull = 1'b0; #1;
    check_bit("R9", "irq released again", irq_line, 1'b1);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule